// File: doc/BRIEF.md
# Sector Page-Load Programmer

This block collects byte writes for one sector of a byte-wide storage array into a page latch, then commits the whole sector in a single timed operation. Software first pulses a program-enable input to arm the block. Byte writes then go into the page latch. The first accepted write fixes which sector is being filled, and later bytes may arrive at any offset in any order.

When no accepted write has arrived for a programmable number of clock cycles, the load window closes and the busy period starts. During the busy period the block first erases the sector and then fills it from the latch. Every offset that was not loaded ends up holding FFh. The busy period lasts a fixed, parameterised number of cycles.

Reads made during the busy period return a status byte instead of array data. Bit 7 of that byte carries the inverse of bit 7 of the most recently accepted byte. Bit 6 flips on every status read. When the busy period ends, reads return the stored contents again.

Top module: `pgld_sector_prog`

## Requirements
- R1: An address is split into a sector number (bits ADDR_W-1..7) and a byte offset (bits 6..0). After programming, the byte at offset k of sector s is stored at address s*128+k.
- R2: Bytes may be loaded at any offsets in any order. Each loaded byte is stored at its own offset.
- R3: A write is accepted only after a program-enable pulse while idle, and only when rd_stb is low in the same cycle. A write with rd_stb high, or a write with no arming, leaves both the array and busy unchanged.
- R4: Once the first byte has fixed the sector, a write addressed to any other sector is ignored.
- R5: busy rises exactly LOAD_TMO cycles after the clock edge that accepted the last write.
- R6: busy stays high for exactly PROG_CYC cycles and then falls.
- R7: The whole sector is rewritten. Any offset not loaded in the current operation reads FFh afterwards, whatever it held before.
- R8: A read issued while busy returns a status byte. Bit 7 is the inverse of bit 7 of the last accepted byte, and bits 5..0 are zero.
- R9: Bit 6 of the status byte is 0 on the first read of a busy period and flips on each later read in that period.
- R10: rvalid is high exactly one cycle after each rd_stb. While not busy, rdata then holds the array byte at the address given with rd_stb.
- R11: After reset, busy and rvalid are low.
- R12: Writes and program-enable pulses issued while busy have no effect. No new busy period starts from them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_en | input | 1 | One-cycle pulse that arms a sector load |
| wr_stb | input | 1 | Byte write strobe |
| rd_stb | input | 1 | Read request; also inhibits a write in the same cycle |
| addr | input | ADDR_W | Sector number and byte offset |
| wdata | input | 8 | Byte to load |
| rdata | output | 8 | Array byte or status byte |
| rvalid | output | 1 | rdata valid, one cycle after rd_stb |
| busy | output | 1 | Erase-and-program period in progress |

## Verification
The assertions assume that PROG_CYC is at least the sector size of 128, so the array write sweep always finishes inside the busy period. They also assume that every status read belongs to a single busy period, and that rd_stb, wr_stb and prog_en change only between clock edges.

The bench drives every input on the falling edge as a one-cycle pulse. It issues only a handful of status reads, well inside each busy period. It configures a small array in which every sector is programmed before it is read, so no read ever touches an unwritten location.

// File: rtl/pgld_pkg.sv
package pgld_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_LOAD  = 2'd2,
    ST_PROG  = 2'd3
  } pgld_state_e;
endpackage

// File: rtl/pgld_array.sv
module pgld_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  // storage: no reset, written only during the program sweep
  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (re) begin
      rdata_q <= mem[raddr];
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/pgld_latch.sv
module pgld_latch #(
  parameter int OFF_W  = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              we,
  input  logic [OFF_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [OFF_W-1:0]  ridx,
  output logic [DATA_W-1:0] rbyte
);
  localparam int PAGE = 1 << OFF_W;

  logic [DATA_W-1:0] data_q [PAGE];
  logic [PAGE-1:0]   hit_q;

  // per-byte loaded flag; cleared when a new load is armed
  for (genvar g = 0; g < PAGE; g++) begin : g_hit
    logic hit_d;
    always_comb begin
      hit_d = hit_q[g];
      if (clr) begin
        hit_d = 1'b0;
      end else if (we && (widx == OFF_W'(g))) begin
        hit_d = 1'b1;
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hit_q[g] <= 1'b0;
      end else begin
        hit_q[g] <= hit_d;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (we) begin
      data_q[widx] <= wdata;
    end
  end

  // an unloaded byte reads as the erased value
  assign rbyte = hit_q[ridx] ? data_q[ridx] : {DATA_W{1'b1}};
endmodule

// File: rtl/pgld_ctrl.sv
module pgld_ctrl
  import pgld_pkg::*;
#(
  parameter int OFF_W    = 7,
  parameter int SEC_W    = 4,
  parameter int LOAD_TMO = 7500,
  parameter int PROG_CYC = 1000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prog_en,
  input  logic             wr_stb,
  input  logic             rd_stb,
  input  logic [SEC_W-1:0] wr_sector,
  input  logic             wr_b7,
  output logic             lat_clr,
  output logic             lat_we,
  output logic             prog_we,
  output logic [OFF_W-1:0] prog_idx,
  output logic [SEC_W-1:0] sector,
  output logic             busy,
  output logic             last_b7,
  output logic             tog
);
  localparam int PAGE = 1 << OFF_W;
  localparam int TMW  = $clog2(LOAD_TMO + 1);
  localparam int PCW  = $clog2(PROG_CYC + 1);

  pgld_state_e      st_q, st_d;
  logic [TMW-1:0]   tmr_q, tmr_d;
  logic [PCW-1:0]   pcnt_q, pcnt_d;
  logic [SEC_W-1:0] sec_q, sec_d;
  logic             b7_q, b7_d;
  logic             tog_q, tog_d;
  logic             acc_wr;

  assign acc_wr = wr_stb && !rd_stb;

  always_comb begin
    st_d    = st_q;
    tmr_d   = tmr_q;
    pcnt_d  = pcnt_q;
    sec_d   = sec_q;
    lat_clr = 1'b0;
    lat_we  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (prog_en) begin
          st_d    = ST_ARMED;
          lat_clr = 1'b1;
        end
      end
      ST_ARMED: begin
        if (acc_wr) begin
          st_d   = ST_LOAD;
          sec_d  = wr_sector;
          lat_we = 1'b1;
          tmr_d  = '0;
        end
      end
      ST_LOAD: begin
        if (acc_wr && (wr_sector == sec_q)) begin
          lat_we = 1'b1;
          tmr_d  = '0;
        end else if (tmr_q == TMW'(LOAD_TMO - 1)) begin
          st_d   = ST_PROG;
          pcnt_d = '0;
        end else begin
          tmr_d = tmr_q + TMW'(1);
        end
      end
      ST_PROG: begin
        if (pcnt_q == PCW'(PROG_CYC - 1)) begin
          st_d = ST_IDLE;
        end else begin
          pcnt_d = pcnt_q + PCW'(1);
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    b7_d  = lat_we ? wr_b7 : b7_q;
    tog_d = tog_q;
    if ((st_q == ST_LOAD) && (st_d == ST_PROG)) begin
      tog_d = 1'b0;
    end else if ((st_q == ST_PROG) && rd_stb) begin
      tog_d = ~tog_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      tmr_q  <= '0;
      pcnt_q <= '0;
      sec_q  <= '0;
      b7_q   <= 1'b0;
      tog_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      tmr_q  <= tmr_d;
      pcnt_q <= pcnt_d;
      sec_q  <= sec_d;
      b7_q   <= b7_d;
      tog_q  <= tog_d;
    end
  end

  assign busy     = (st_q == ST_PROG);
  assign prog_we  = busy && (pcnt_q < PCW'(PAGE));
  assign prog_idx = pcnt_q[OFF_W-1:0];
  assign sector   = sec_q;
  assign last_b7  = b7_q;
  assign tog      = tog_q;
endmodule

// File: rtl/pgld_sector_prog.sv
module pgld_sector_prog #(
  parameter int ADDR_W   = 11,
  parameter int OFF_W    = 7,
  parameter int LOAD_TMO = 7500,
  parameter int PROG_CYC = 1000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_en,
  input  logic              wr_stb,
  input  logic              rd_stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              rvalid,
  output logic              busy
);
  localparam int SEC_W = ADDR_W - OFF_W;

  logic             lat_clr, lat_we, prog_we, last_b7, tog;
  logic [OFF_W-1:0] prog_idx;
  logic [SEC_W-1:0] sector;
  logic [7:0]       lat_byte, mem_q;
  logic             rvalid_q, stat_sel_q;
  logic [7:0]       stat_q;

  pgld_ctrl #(
    .OFF_W(OFF_W), .SEC_W(SEC_W), .LOAD_TMO(LOAD_TMO), .PROG_CYC(PROG_CYC)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .wr_stb(wr_stb),
    .rd_stb(rd_stb), .wr_sector(addr[ADDR_W-1:OFF_W]), .wr_b7(wdata[7]),
    .lat_clr(lat_clr), .lat_we(lat_we), .prog_we(prog_we),
    .prog_idx(prog_idx), .sector(sector), .busy(busy),
    .last_b7(last_b7), .tog(tog)
  );

  pgld_latch #(.OFF_W(OFF_W), .DATA_W(8)) u_latch (
    .clk(clk), .rst_n(rst_n), .clr(lat_clr), .we(lat_we),
    .widx(addr[OFF_W-1:0]), .wdata(wdata), .ridx(prog_idx),
    .rbyte(lat_byte)
  );

  pgld_array #(.ADDR_W(ADDR_W), .DATA_W(8)) u_array (
    .clk(clk), .we(prog_we), .waddr({sector, prog_idx}), .wdata(lat_byte),
    .re(rd_stb), .raddr(addr), .rdata(mem_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q   <= 1'b0;
      stat_sel_q <= 1'b0;
      stat_q     <= '0;
    end else begin
      rvalid_q <= rd_stb;
      if (rd_stb) begin
        stat_sel_q <= busy;
        stat_q     <= {~last_b7, tog, 6'b0};
      end
    end
  end

  assign rvalid = rvalid_q;
  assign rdata  = stat_sel_q ? stat_q : mem_q;
endmodule

// File: rtl/pgld_sector_prog_chk.sv
module pgld_sector_prog_chk #(
  parameter int PROG_CYC = 1000000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_stb,
  input logic       rvalid,
  input logic       busy,
  input logic       stat_sel,
  input logic       rd_bit6,
  input logic [5:0] rd_low
);
  logic [31:0] run_q;
  logic        busy_d1, seen_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      busy_d1 <= 1'b0;
      seen_q  <= 1'b0;
      prev_q  <= 1'b0;
    end else begin
      run_q   <= busy ? run_q + 32'd1 : 32'd0;
      busy_d1 <= busy;
      if (busy && !busy_d1) begin
        seen_q <= 1'b0;
      end else if (rvalid && stat_sel) begin
        seen_q <= 1'b1;
        prev_q <= rd_bit6;
      end
    end
  end

  // R10
  rvalid_follows_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> rvalid);
  // R10
  rvalid_only_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> !rvalid);
  // R6
  busy_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_q == 32'(PROG_CYC)));
  // R9
  toggle_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && stat_sel && !seen_q) |-> !rd_bit6);
  // R9
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && stat_sel && seen_q) |-> (rd_bit6 != prev_q));
  // R8
  status_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && stat_sel) |-> (rd_low == 6'd0));
endmodule

bind pgld_sector_prog pgld_sector_prog_chk #(.PROG_CYC(PROG_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rvalid(rvalid), .busy(busy),
  .stat_sel(stat_sel_q), .rd_bit6(rdata[6]), .rd_low(rdata[5:0])
);

// File: tb/pgld_sector_prog_tb.sv
module pgld_sector_prog_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 10;
  localparam int TMO  = 8;
  localparam int PCYC = 140;
  localparam int NSEC = 1 << (AW - 7);

  logic clk, rst_n, prog_en, wr_stb, rd_stb, rvalid, busy;
  logic [AW-1:0] addr;
  logic [7:0] wdata, rdata;
  int n_chk, n_fail, cyc;
  bit done;
  logic [7:0] model [1 << AW];

  pgld_sector_prog #(.ADDR_W(AW), .OFF_W(7), .LOAD_TMO(TMO), .PROG_CYC(PCYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .wr_stb(wr_stb),
    .rd_stb(rd_stb), .addr(addr), .wdata(wdata), .rdata(rdata),
    .rvalid(rvalid), .busy(busy)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic do_write(input int a, input int d, input bit with_rd);
    @(negedge clk);
    wr_stb = 1'b1; rd_stb = with_rd; addr = AW'(a); wdata = 8'(d);
    @(negedge clk);
    wr_stb = 1'b0; rd_stb = 1'b0;
  endtask

  task automatic do_arm();
    @(negedge clk); prog_en = 1'b1;
    @(negedge clk); prog_en = 1'b0;
  endtask

  task automatic do_read(input int a, output logic [7:0] v, output logic vld);
    @(negedge clk); rd_stb = 1'b1; addr = AW'(a);
    @(negedge clk); rd_stb = 1'b0;
    v = rdata; vld = rvalid;
  endtask

  function automatic int pat(input int s, input int k);
    return (s * 29 + k * 7 + 3) & 8'hFF;
  endfunction

  // waits for busy, checks timeout, status reads, busy length
  task automatic run_prog(input int s, input int lastd);
    int c0, cr;
    logic [7:0] v; logic vld;
    c0 = cyc;
    while (!busy) @(negedge clk);
    cr = cyc;
    chk(cr - c0 == TMO, "R5 load timeout", cr - c0, TMO);
    for (int r = 0; r < 4; r++) begin
      do_read(s * 128, v, vld);
      chk(vld && v[7] == ~lastd[7] && v[5:0] == 0, "R8 status bits", v, {~lastd[7], 7'b0});
      chk(v[6] == r[0], "R9 toggle bit", v[6], r[0]);
    end
    do_arm();                                    // R12: ignored while busy
    do_write(s * 128, 8'h5A, 1'b0);              // R12: ignored while busy
    while (busy) @(negedge clk);
    chk(cyc - cr == PCYC, "R6 busy length", cyc - cr, PCYC);
  endtask

  task automatic verify_sector(input int s, input string req);
    logic [7:0] v; logic vld;
    for (int k = 0; k < 128; k++) begin
      do_read(s * 128 + k, v, vld);
      chk(vld, "R10 rvalid", vld, 1);
      chk(v === model[s * 128 + k], req, v, model[s * 128 + k]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int lastd, k0, k1;
    logic [7:0] v; logic vld;
    n_chk = 0; n_fail = 0; cyc = 0; done = 0;
    rst_n = 1'b0; prog_en = 0; wr_stb = 0; rd_stb = 0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !rvalid, "R11 reset state", {busy, rvalid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !rvalid, "R11 after release", {busy, rvalid}, 0);

    // R1 R2 R4 R3 R7: every sector, permuted order, odd sectors sparse
    for (int s = 0; s < NSEC; s++) begin
      do_arm();
      lastd = 0;
      k0 = (s * 11) % 128;
      k1 = (37 + s * 11) % 128;
      for (int i = 0; i < 128; i++) begin
        int k;
        k = (i * 37 + s * 11) % 128;
        if (i == 64) do_write(s * 128 + k0, ~pat(s, k0), 1'b1);        // R3 inhibited
        if (i == 65) do_write(((s + 1) % NSEC) * 128 + k1, ~pat(s, k1), 1'b0); // R4
        if (!(s[0] && (k % 5 == 0))) begin
          do_write(s * 128 + k, pat(s, k), 1'b0);
          lastd = pat(s, k);
        end
      end
      for (int k = 0; k < 128; k++)
        model[s * 128 + k] = (s[0] && (k % 5 == 0)) ? 8'hFF : 8'(pat(s, k));
      run_prog(s, lastd);
      verify_sector(s, "R1 R2 R4 R7 sector contents");
    end

    // R7: partial reload of sector 2, reverse order, erases the rest
    do_arm();
    for (int k = 9; k >= 0; k--) do_write(2 * 128 + k, k ^ 8'hA5, 1'b0);
    for (int k = 0; k < 128; k++) model[2 * 128 + k] = (k < 10) ? 8'(k ^ 8'hA5) : 8'hFF;
    run_prog(2, 0 ^ 8'hA5);
    verify_sector(2, "R7 erase on reprogram");

    // R3 R12: write with no arming starts nothing and changes nothing
    do_write(5, 8'h00, 1'b0);
    repeat (TMO + 4) begin
      @(negedge clk);
      chk(!busy, "R3 R12 no busy without arm", busy, 0);
    end
    do_read(5, v, vld);
    chk(v === model[5], "R3 unarmed write ignored", v, model[5]);

    // R1 R10: full sweep, neighbours untouched
    for (int s = 0; s < NSEC; s++) verify_sector(s, "R1 R10 full sweep");
    summary();
  end
endmodule